// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between a synchronous host and an external 1M x 16 asynchronous static RAM. The host issues a one-cycle request carrying a write flag, a 20-bit word address, 16-bit write data and a 2-bit byte mask. The controller turns each request into a strobe sequence whose lengths are counted in clock cycles. The cycle counts are derived from nanosecond parameters and a clock-period parameter, always rounded up. Completion is signalled by a one-cycle `done_o` pulse. For reads, the captured data is valid on `rdata_o` from that pulse onward.

The memory side has two chip selects of opposite polarity, an active-low write enable, an active-low output enable and two active-low byte-lane selects. There is also a data output with a single tristate enable, and a data input. A memory write can only happen where all of these overlap: both chip selects active, write enable low and at least one lane select low. The controller never enables the RAM outputs while it drives the bus itself. After output enable is released, it waits out the high-impedance time before it drives the bus.

The state machine has six states. `ST_IDLE` goes to `ST_RD_ACCESS` on a read request and to `ST_WR_SETUP` on a write request. `ST_RD_ACCESS` goes to `ST_RD_RELEASE` when the access count expires. `ST_RD_RELEASE` goes to `ST_IDLE` when the high-Z count expires. `ST_WR_SETUP` always goes to `ST_WR_PULSE` after one cycle. `ST_WR_PULSE` goes to `ST_WR_RECOVER` when the pulse count expires. `ST_WR_RECOVER` goes to `ST_IDLE` after one cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset and whenever the controller is idle, the outputs are as follows: `mem_cs_n_o`=1, `mem_cs_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_lane_n_o`=2'b11, `mem_dq_oe_o`=0 and `done_o`=0.
- R2: A write drives the address, both chip selects and the lane selects for one setup cycle with `mem_we_n_o` high. It then holds `mem_we_n_o` low for exactly the write-pulse count: the ceiling of the largest of 55, 65, 65 and 35 ns over the clock period, which is 7 cycles at 10 ns. The memory content after the write equals the host's write data on the selected lanes.
- R3: During a write, `mem_dq_oe_o` is high from the setup cycle through one cycle after `mem_we_n_o` rises. `mem_dq_o` does not change while `mem_we_n_o` is low.
- R4: Mask bit 0 selects the lower lane (DQ[7:0], `mem_lane_n_o[0]` low). Mask bit 1 selects the upper lane (DQ[15:8], `mem_lane_n_o[1]` low). An unselected lane keeps its select high, is not written, and reads back as 8'h00 on `rdata_o`.
- R5: A read holds `mem_oe_n_o` low and `mem_we_n_o` high for the read-access count: the ceiling of 70 ns over the clock period, which is 7 cycles. `rdata_o` is captured from `mem_dq_i` at the clock edge that ends this window.
- R6: `done_o` is high for exactly one cycle. It is first seen 7 cycles after the request edge for a read and 9 cycles after it for a write.
- R7: `mem_dq_oe_o` is never high while `mem_oe_n_o` is low, and it rises only after `mem_oe_n_o` has been high for at least the high-Z count: the ceiling of 25 ns over the clock period, which is 3 cycles. `mem_oe_n_o` is never low together with `mem_we_n_o` low.
- R8: A request raised while an access is in progress is ignored. It produces no memory write and no extra `done_o`, and the address stays stable while the chip is selected.
- R9: A write with mask 2'b00 still completes with `done_o` but selects no lane, so the memory word keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle access request, taken only when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Byte mask, bit 0 lower lane, bit 1 upper lane |
| rdata_o | output | 16 | Read data, unselected lanes zero |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 20 | Address to the RAM |
| mem_cs_n_o | output | 1 | Active-low chip select |
| mem_cs_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write enable |
| mem_oe_n_o | output | 1 | Active-low output enable |
| mem_lane_n_o | output | 2 | Active-low lane selects, bit 0 lower |
| mem_dq_o | output | 16 | Data driven to the RAM |
| mem_dq_oe_o | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data returned by the RAM |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is still running. The controller must ignore it, and the only sign that it did so correctly is the absence of a memory write and of a second done pulse. The bench injects a write request two cycles into a read. It then watches a behavioural RAM model for a stray write window and counts done pulses over a quiet interval. A second hard case is the read-to-write bus handover. It is reached by issuing a write directly after a read completes, while the model checks how long output enable has been released when the bus driver turns on. The RAM model returns a garbage word until output enable has been low for the full access count, so sampling the data early also shows up as a mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RELEASE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctl_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

    // R2: a zero load would make a timed state never end
    a_r2_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0));

endmodule

// File: rtl/sram_lane_gate.sv
module sram_lane_gate #(
    parameter int unsigned LANES  = 2,
    parameter int unsigned LANE_W = 8
) (
    input  logic                      sel_en_i,
    input  logic [LANES-1:0]          sel_mask_i,
    input  logic [LANES-1:0]          rd_mask_i,
    input  logic [LANES*LANE_W-1:0]   dq_i,
    output logic [LANES-1:0]          lane_n_o,
    output logic [LANES*LANE_W-1:0]   rd_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n_o[g]               = !(sel_en_i && sel_mask_i[g]);
        assign rd_o[g*LANE_W +: LANE_W]  = rd_mask_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned LANES   = 2,
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_RC_NS = 70,
    parameter int unsigned T_AA_NS = 70,
    parameter int unsigned T_WP_NS = 55,
    parameter int unsigned T_CW_NS = 65,
    parameter int unsigned T_AW_NS = 65,
    parameter int unsigned T_DW_NS = 35,
    parameter int unsigned T_HZ_NS = 25
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     wr_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [LANES*LANE_W-1:0]  wdata_i,
    input  logic [LANES-1:0]         mask_i,
    output logic [LANES*LANE_W-1:0]  rdata_o,
    output logic                     done_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic                     mem_cs_n_o,
    output logic                     mem_cs_o,
    output logic                     mem_we_n_o,
    output logic                     mem_oe_n_o,
    output logic [LANES-1:0]         mem_lane_n_o,
    output logic [LANES*LANE_W-1:0]  mem_dq_o,
    output logic                     mem_dq_oe_o,
    input  logic [LANES*LANE_W-1:0]  mem_dq_i
);

    localparam int unsigned DATA_W  = LANES * LANE_W;
    localparam int unsigned RD_CYC  = ns_to_cycles(max_of(T_RC_NS, T_AA_NS), CLK_NS);
    localparam int unsigned WP_CYC  = ns_to_cycles(max_of(max_of(T_WP_NS, T_CW_NS),
                                                          max_of(T_AW_NS, T_DW_NS)), CLK_NS);
    localparam int unsigned HZ_CYC  = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int unsigned MAX_CYC = max_of(max_of(RD_CYC, WP_CYC), HZ_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e state_q, state_nxt;

    logic               accept;
    logic               t_load, t_last;
    logic [CNT_W-1:0]   t_val;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   mask_q, mask_nxt;
    logic               cs_nxt;
    logic [LANES-1:0]   lane_nxt;
    logic [DATA_W-1:0]  rd_gated;
    logic               rd_capture;

    assign accept     = (state_q == ST_IDLE) && req_i;
    assign rd_capture = (state_q == ST_RD_ACCESS) && t_last;
    assign mask_nxt   = accept ? mask_i : mask_q;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_i)  state_nxt = wr_i ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (t_last) state_nxt = ST_RD_RELEASE;
            ST_RD_RELEASE: if (t_last) state_nxt = ST_IDLE;
            ST_WR_SETUP:               state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:   if (t_last) state_nxt = ST_WR_RECOVER;
            ST_WR_RECOVER:             state_nxt = ST_IDLE;
            default:                   state_nxt = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // ---------------- cycle timer ----------------
    assign t_load = (state_nxt != state_q);

    always_comb begin
        unique case (state_nxt)
            ST_RD_ACCESS:  t_val = CNT_W'(RD_CYC);
            ST_RD_RELEASE: t_val = CNT_W'(HZ_CYC);
            ST_WR_PULSE:   t_val = CNT_W'(WP_CYC);
            default:       t_val = CNT_W'(1);
        endcase
    end

    sram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .last_o     (t_last)
    );

    // ---------------- request capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            mask_q  <= mask_i;
        end
    end

    // ---------------- lane gating ----------------
    assign cs_nxt = (state_nxt == ST_RD_ACCESS) || (state_nxt == ST_WR_SETUP) ||
                    (state_nxt == ST_WR_PULSE);

    sram_lane_gate #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .sel_en_i   (cs_nxt),
        .sel_mask_i (mask_nxt),
        .rd_mask_i  (mask_q),
        .dq_i       (mem_dq_i),
        .lane_n_o   (lane_nxt),
        .rd_o       (rd_gated)
    );

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_cs_n_o   <= 1'b1;
            mem_cs_o     <= 1'b0;
            mem_we_n_o   <= 1'b1;
            mem_oe_n_o   <= 1'b1;
            mem_lane_n_o <= '1;
            mem_dq_oe_o  <= 1'b0;
            done_o       <= 1'b0;
            rdata_o      <= '0;
        end else begin
            mem_cs_n_o   <= !cs_nxt;
            mem_cs_o     <= cs_nxt;
            mem_we_n_o   <= (state_nxt != ST_WR_PULSE);
            mem_oe_n_o   <= (state_nxt != ST_RD_ACCESS);
            mem_lane_n_o <= lane_nxt;
            mem_dq_oe_o  <= (state_nxt == ST_WR_SETUP) || (state_nxt == ST_WR_PULSE) ||
                            (state_nxt == ST_WR_RECOVER);
            done_o       <= rd_capture || (state_q == ST_WR_RECOVER);
            if (rd_capture) rdata_o <= rd_gated;
        end
    end

    assign mem_addr_o = addr_q;
    assign mem_dq_o   = wdata_q;

    // ---------------- assertions ----------------
    // cycles output enable has stayed released; bus idle in reset counts as released
    logic [CNT_W-1:0] oe_idle_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          oe_idle_q <= CNT_W'(HZ_CYC);
        else if (!mem_oe_n_o)                oe_idle_q <= '0;
        else if (oe_idle_q < CNT_W'(HZ_CYC)) oe_idle_q <= oe_idle_q + 1'b1;
    end

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o);

    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (oe_idle_q >= CNT_W'(HZ_CYC)));

    a_r7_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> mem_we_n_o);

    a_r2_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_dq_oe_o));

    a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o && $past(!mem_we_n_o)) |-> $stable(mem_dq_o));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));

    a_r1_cs_pair: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_o == !mem_cs_n_o);

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
module sram_strobe_ctrl_tb_top;

    localparam int WP_CYC = 7;
    localparam int RD_CYC = 7;
    localparam int HZ_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  mask = '0;
    logic [15:0] rdata;
    logic        done;
    logic [19:0] m_addr;
    logic        m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe;
    logic [1:0]  m_lane_n;
    logic [15:0] m_dq_o;
    logic [15:0] m_dq_i = 16'hDEAD;

    always #5 clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .mask_i(mask), .rdata_o(rdata), .done_o(done),
        .mem_addr_o(m_addr), .mem_cs_n_o(m_cs_n), .mem_cs_o(m_cs),
        .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n), .mem_lane_n_o(m_lane_n),
        .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] mdl_mem [bit [19:0]];
    logic [15:0] exp_mem [bit [19:0]];
    int mdl_writes = 0;
    int done_cnt = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return mdl_mem.exists(a) ? mdl_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] exp_read(input logic [19:0] a, input logic [1:0] m);
        logic [15:0] v;
        v = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    // ---------------- behavioural RAM model and strobe checker ----------------
    int          we_lo = 0;
    int          oe_lo = 0;
    int          oe_hi = 100;
    logic [15:0] wd_seen = '0;
    logic [19:0] wa_seen = '0;
    logic [1:0]  lanes_seen = '0;
    bit          wd_changed = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!m_we_n) begin
                if (we_lo > 0 && m_dq_o !== wd_seen) wd_changed = 1;
                wd_seen    = m_dq_o;
                wa_seen    = m_addr;
                lanes_seen = (!m_cs_n && m_cs) ? ~m_lane_n : 2'b00;
                we_lo++;
            end else if (we_lo > 0) begin
                check("R2", we_lo, WP_CYC, "write pulse length");
                check("R3", {31'd0, wd_changed}, 32'd0, "data change inside write window");
                check("R3", {31'd0, m_dq_oe}, 32'd1, "data held after write end");
                if (lanes_seen != 2'b00) begin
                    logic [15:0] w;
                    w = mem_word(wa_seen);
                    if (lanes_seen[0]) w[7:0]  = wd_seen[7:0];
                    if (lanes_seen[1]) w[15:8] = wd_seen[15:8];
                    mdl_mem[wa_seen] = w;
                    mdl_writes++;
                end
                we_lo = 0;
                wd_changed = 0;
            end
            if (m_dq_oe && !m_oe_n) begin
                errors++; checks++;
                $display("FAIL R7 bus contention: actual dq_oe=1 oe_n=0 expected oe_n=1");
            end
            if ($rose(m_dq_oe) && oe_hi < HZ_CYC) begin
                errors++; checks++;
                $display("FAIL R7 turnaround: actual %0d expected >= %0d", oe_hi, HZ_CYC);
            end
            if (!m_oe_n && !m_we_n) begin
                errors++; checks++;
                $display("FAIL R7 oe/we overlap: actual both low expected we_n=1");
            end
            oe_hi = m_oe_n ? ((oe_hi < 100) ? oe_hi + 1 : oe_hi) : 0;
            if (!m_oe_n && !m_cs_n && m_cs) oe_lo++;
            else                            oe_lo = 0;
            if (oe_lo >= RD_CYC) begin
                logic [15:0] v;
                v = mem_word(m_addr);
                m_dq_i = {!m_lane_n[1] ? v[15:8] : 8'h5A, !m_lane_n[0] ? v[7:0] : 8'h5A};
            end else begin
                m_dq_i = 16'hDEAD;
            end
            if (done) done_cnt++;
        end
    end

    task automatic check_idle(input string tag);
        check(tag, {26'd0, m_cs_n, m_cs, m_we_n, m_oe_n, m_lane_n},
              {26'd0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11}, "idle strobes");
        check(tag, {30'd0, m_dq_oe, done}, 32'd0, "idle bus/done");
    endtask

    task automatic run_op(input bit w, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit poke);
        int lat;
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; mask = m;
        @(negedge clk);
        req = 1'b0; wdata = 16'h0; addr = '0;
        lat = 0;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 2) begin
                req = 1'b1; wr = 1'b1; addr = a ^ 20'h1; wdata = ~d; mask = 2'b11;
            end else begin
                req = 1'b0;
            end
        end
        req = 1'b0;
        check("R6", lat, w ? 9 : 7, "done latency");
        if (w) begin
            logic [15:0] v;
            v = exp_mem.exists(a) ? exp_mem[a] : 16'h0000;
            if (m[0]) v[7:0]  = d[7:0];
            if (m[1]) v[15:8] = d[15:8];
            exp_mem[a] = v;
        end else begin
            check(m == 2'b11 ? "R5" : "R4", rdata, exp_read(a, m), "read data");
        end
        @(negedge clk);
        check("R6", {31'd0, done}, 32'd0, "done width");
        @(negedge clk);
        @(negedge clk);
        check_idle("R1");
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0, w0;
        void'($urandom(32'd4321));
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        // directed: full word, lane-only writes, boundary addresses
        run_op(1, 20'h00000, 16'h1234, 2'b11, 0);
        run_op(0, 20'h00000, 16'h0, 2'b11, 0);
        run_op(1, 20'hFFFFF, 16'hA1B2, 2'b11, 0);
        run_op(1, 20'hFFFFF, 16'hC3D4, 2'b01, 0);
        run_op(0, 20'hFFFFF, 16'h0, 2'b11, 0);
        run_op(1, 20'hFFFFF, 16'hE5F6, 2'b10, 0);
        run_op(0, 20'hFFFFF, 16'h0, 2'b11, 0);
        run_op(0, 20'hFFFFF, 16'h0, 2'b01, 0);
        run_op(0, 20'hFFFFF, 16'h0, 2'b10, 0);
        // R9: empty mask writes nothing
        w0 = mdl_writes;
        run_op(1, 20'h00000, 16'hFFFF, 2'b00, 0);
        check("R9", mdl_writes - w0, 0, "writes from empty mask");
        run_op(0, 20'h00000, 16'h0, 2'b11, 0);
        // R8: request during a read is ignored
        w0 = mdl_writes;
        d0 = done_cnt;
        run_op(0, 20'h00000, 16'h5555, 2'b11, 1);
        repeat (15) @(negedge clk);
        check("R8", mdl_writes - w0, 0, "writes from busy request");
        check("R8", done_cnt - d0, 1, "done pulses for one access");
        run_op(0, 20'h00001, 16'h0, 2'b11, 0);

        // random mix over a small address pool, read-to-write back to back
        for (int i = 0; i < 60; i++) begin
            logic [19:0] a;
            a = ($urandom % 2) ? (20'hFFFFF - 20'($urandom % 4)) : 20'($urandom % 6);
            run_op(bit'($urandom % 2), a, 16'($urandom), 2'($urandom), 0);
        end

        // R2: model memory matches the host view
        foreach (exp_mem[k]) check("R2", mem_word(k), exp_mem[k], "memory content");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule